// File: doc/BRIEF.md
# Periodic Interval Timer with Atomic Interval Reload

This block raises a periodic interrupt. A slow tick (nominally 32.768 kHz, given as a one-cycle enable in the system clock domain) decrements a down-counter. Each time the counter finishes a period, the block emits a one-clock interrupt pulse and reloads the counter from the active interval without any software action. The period in seconds is the interval divided by 32768.

Software sees the 32-bit interval as four byte registers. Address 0 holds the most significant byte and address 3 holds the least significant byte. Writes to the three upper addresses only fill a staging register. The write to address 3 moves the staged bytes and the new low byte into the active interval in a single cycle, so the counter never runs from a half-updated value. An active interval of zero stops the timer.

Top module: `pit_timer`

## Requirements
- R1: After reset, reads of addresses 0 to 3 all return 0x00 and `irq_pulse` stays low, because the interval resets to zero.
- R2: Address 0 holds interval bits [31:24], address 1 bits [23:16] and address 2 bits [15:8]. A write to any of these three addresses updates only the staging byte, and a later read of that address returns it. The active interval and the running count do not change.
- R3: A write to address 3 makes the active interval equal to {staged bytes at addresses 0, 1, 2, written byte}. A read of address 3 returns the low byte of the active interval.
- R4: With a nonzero active interval N, `irq_pulse` is high for exactly one clock, one clock after the Nth tick counted from the commit.
- R5: After each interrupt the counter reloads from the active interval, so interrupts repeat every N ticks indefinitely.
- R6: While the active interval is zero, no tick produces an interrupt.
- R7: A commit restarts the count from the new interval at once. Ticks counted before the commit are discarded, and a tick in the same cycle as the commit is ignored.
- R8: An interval of 1 produces an interrupt after every tick.
- R9: Writes to addresses above 3 change no register and no timing. Reads of those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle enable per 32.768 kHz tick |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Write data byte |
| reg_rdata | output | 8 | Read data byte for `reg_addr` (combinational) |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest case to reach is a staged upper byte that differs from the active interval while the counter is partway through a period. Only then does a wrong early commit show up as changed interrupt timing. The stimulus commits an interval, spends some ticks, and writes new upper bytes. It then counts the ticks to the next interrupt against the old interval and reads back the staged bytes. A 256-tick interval makes sure the upper bytes really reach the counter.

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int NBYTES = 4,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq_pulse
);
  localparam int W    = NBYTES * 8;
  localparam int SW   = W - 8;
  localparam int LAST = NBYTES - 1;

  logic [SW-1:0] stage;
  logic [W-1:0]  active;
  logic [W-1:0]  count;
  logic          commit;
  logic          running;
  logic          expire;

  assign commit  = reg_wr && (reg_addr == ADDR_W'(LAST));
  assign running = (active != '0);
  assign expire  = running && tick_en && (count == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage <= '0;
    end else begin
      for (int i = 0; i < LAST; i++)
        if (reg_wr && reg_addr == ADDR_W'(i))
          stage[(LAST-1-i)*8 +: 8] <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active    <= '0;
      count     <= '0;
      irq_pulse <= 1'b0;
    end else begin
      irq_pulse <= 1'b0;
      if (commit) begin
        active <= {stage, reg_wdata};
        count  <= {stage, reg_wdata};
      end else if (running && tick_en) begin
        if (expire) begin
          count     <= active;
          irq_pulse <= 1'b1;
        end else begin
          count <= count - W'(1);
        end
      end
    end
  end

  always_comb begin
    reg_rdata = 8'h00;
    for (int i = 0; i < LAST; i++)
      if (reg_addr == ADDR_W'(i))
        reg_rdata = stage[(LAST-1-i)*8 +: 8];
    if (reg_addr == ADDR_W'(LAST))
      reg_rdata = active[7:0];
  end

  // R2
  stage_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr < ADDR_W'(LAST)) |=> $stable(active));

  // R3
  commit_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> active == {$past(stage), $past(reg_wdata)});

  // R4
  irq_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> $past(tick_en));

  // R6
  zero_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active == '0) |=> !irq_pulse);

  // R7
  commit_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !irq_pulse);

  // R9
  high_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr > ADDR_W'(LAST)) |=> ($stable(active) && $stable(stage)));
endmodule

// File: tb/pit_timer_bench.sv
module pit_timer_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       tick_en = 0;
  logic       reg_wr = 0;
  logic [7:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata;
  logic       irq_pulse;
  int checks = 0;
  int errors = 0;
  int irqs = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pit_timer u_pit_timer (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pulse(irq_pulse));

  always @(negedge clk) if (irq_pulse) irqs++;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic set_interval(input logic [31:0] v);
    wr(8'd0, v[31:24]); wr(8'd1, v[23:16]); wr(8'd2, v[15:8]); wr(8'd3, v[7:0]);
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick_en = 1;
      @(negedge clk);
      tick_en = 0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(8'(a), v);
      check("R1 reset read", v, 0);
    end
    irqs = 0;
    ticks(5);
    check("R1 no irq after reset", irqs, 0);
  endtask

  task automatic t_period;
    set_interval(32'd5);
    irqs = 0;
    ticks(4);
    check("R4 before Nth tick", irqs, 0);
    ticks(1);
    check("R4 on Nth tick", irqs, 1);
    ticks(15);
    check("R5 periodic reload", irqs, 4);
  endtask

  task automatic t_one_cycle;
    set_interval(32'd2);
    tick_en = 1; @(negedge clk); tick_en = 0;
    tick_en = 1; @(negedge clk); tick_en = 0;
    check("R4 pulse high", int'(irq_pulse), 1);
    @(negedge clk);
    check("R4 pulse one cycle", int'(irq_pulse), 0);
  endtask

  task automatic t_one;
    set_interval(32'd1);
    irqs = 0;
    ticks(7);
    check("R8 every tick", irqs, 7);
  endtask

  task automatic t_restart;
    set_interval(32'd6);
    irqs = 0;
    ticks(4);
    set_interval(32'd4);
    ticks(3);
    check("R7 partial discarded", irqs, 0);
    ticks(1);
    check("R7 new period", irqs, 1);
  endtask

  task automatic t_staging;
    int v;
    set_interval(32'd4);
    irqs = 0;
    ticks(2);
    wr(8'd0, 8'h12); wr(8'd1, 8'h34); wr(8'd2, 8'h56);
    ticks(1);
    check("R2 active unchanged early", irqs, 0);
    ticks(1);
    check("R2 old period holds", irqs, 1);
    rd(8'd0, v); check("R2 read addr0", v, 8'h12);
    rd(8'd1, v); check("R2 read addr1", v, 8'h34);
    rd(8'd2, v); check("R2 read addr2", v, 8'h56);
    rd(8'd3, v); check("R3 read committed low", v, 8'h04);
  endtask

  task automatic t_wide;
    int v;
    set_interval(32'h0000_0100);
    rd(8'd3, v); check("R3 low byte after wide commit", v, 0);
    irqs = 0;
    ticks(255);
    check("R3 upper bytes reach counter", irqs, 0);
    ticks(1);
    check("R3 256-tick interval", irqs, 1);
  endtask

  task automatic t_zero;
    set_interval(32'd0);
    irqs = 0;
    ticks(10);
    check("R6 zero disables", irqs, 0);
  endtask

  task automatic t_high_addr;
    int v;
    set_interval(32'd3);
    wr(8'h04, 8'hAA);
    wr(8'h10, 8'h01);
    rd(8'h04, v); check("R9 read high addr 4", v, 0);
    rd(8'hFF, v); check("R9 read high addr FF", v, 0);
    rd(8'd0, v); check("R9 addr0 untouched", v, 0);
    rd(8'd3, v); check("R9 addr3 untouched", v, 3);
    irqs = 0;
    ticks(6);
    check("R9 timing unchanged", irqs, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_period();
    t_one_cycle();
    t_one();
    t_restart();
    t_staging();
    t_wide();
    t_zero();
    t_high_addr();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule